// File: doc/BRIEF.md
# Acquisition Trigger and Record Controller

This block decides when a sample decimator is allowed to collect data and for how long. A record is started by one of three sources: a free-running automatic mode, an edge on one of four digital inputs, or a one-cycle software force pulse. Once a trigger is accepted, the controller waits a programmable number of clock cycles. It then raises a capture-enable gate, keeps it raised for a programmed number of decimated samples, and drops it again.

The decimator reports each decimated sample it produces on a strobe input. The controller counts these strobes to find the end of a record. In automatic mode the end of one record is itself the next trigger. The programmed delay then becomes dead time between records, and a zero delay gives an unbroken stream at the decimated rate. A waiting flag shows software that the controller is armed and idle. Clearing the acquisition enable stops everything at once.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: With a length value L latched at record start, captureEn stays high through exactly L+1 sampleStrobe pulses and is low in the cycle after the edge that takes the last one (automatic mode off).
- R2: For a programmed delay D, captureEn first goes high after the D-th clock edge following the edge that accepts the trigger; with D=0 it goes high right after the accepting edge.
- R3: In automatic mode the edge that takes the last sample of a record also accepts the next trigger, so captureEn is low for exactly D cycles between records, and stays high without a break when D=0.
- R4: In external mode extSel (0 to 3) picks the digital input. extFalling=0 triggers on a 0-to-1 change and extFalling=1 on a 1-to-0 change; changes on unselected inputs, and changes of the other polarity, start nothing.
- R5: Each digital input passes through two synchronizing flops and one edge register. A change applied before clock edge e is accepted at edge e+2, so with D=0 captureEn is high after edge e+2 and still low after edge e+1.
- R6: Automatic mode starts records with no input activity whatever the external setting. With both modes off, only forceTrig=1 starts a record.
- R7: Triggers of any source that arrive during the delay or the capture phase are neither acted on nor remembered.
- R8: When acqEnable is 0, captureEn is low from the next clock edge on and no trigger is accepted; after it is set again the controller is idle and waiting.
- R9: waiting is 1 exactly when acqEnable is 1 and the controller is idle and has no pending delay or record.
- R10: After reset captureEn is 0 and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqEnable | input | 1 | Acquisition enable; 0 stops capture and blocks triggers |
| autoMode | input | 1 | Automatic re-trigger mode (highest precedence) |
| extMode | input | 1 | External edge trigger mode |
| extSel | input | 2 | Index of the digital input used as the trigger |
| extFalling | input | 1 | 1 selects the falling edge, 0 the rising edge |
| forceTrig | input | 1 | One-cycle software trigger pulse |
| delayCycles | input | 16 | Delay from trigger acceptance to capture, in clock cycles |
| recordLen | input | 16 | Samples per record minus one |
| digIn | input | 4 | Asynchronous digital inputs |
| sampleStrobe | input | 1 | One pulse per decimated sample |
| captureEn | output | 1 | Gate that lets the decimator collect samples |
| waiting | output | 1 | Armed and idle, waiting for a trigger |

## Verification
The gate is driven by four kinds of trigger: a forced pulse, rising and falling edges on a selected input, automatic mode with zero delay, and automatic mode with a nonzero delay. Each case is measured cycle by cycle. The forced pulse pins down the delay arithmetic and the length count without synchronizer latency. The input edges separate the selected channel and polarity from unselected channels and the wrong polarity, and fix the three-edge synchronizer latency. The two automatic patterns tell a seamless hand-over apart from a dead gap of the programmed length. Extra triggers are injected while a record is running, and the enable is dropped mid-record. These cases show that busy-time triggers are dropped rather than queued, and that the stop takes effect on the next edge.

// File: rtl/capture_trig_pkg.sv
package capture_trig_pkg;

  typedef enum logic [1:0] {
    ST_WAIT    = 2'd0,
    ST_DELAY   = 2'd1,
    ST_CAPTURE = 2'd2
  } trigState_t;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic loadDelay;
    logic stepDelay;
    logic loadLength;
    logic stepLength;
  } trigStrobe_t;

endpackage

// File: rtl/capture_trig_datapath.sv
module capture_trig_datapath
  import capture_trig_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int SEL_W   = 2,
  parameter int DELAY_W = 16,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  digIn,
  input  logic [SEL_W-1:0]   extSel,
  input  logic               extFalling,
  input  logic [DELAY_W-1:0] delayCycles,
  input  logic [LEN_W-1:0]   recordLen,
  input  trigStrobe_t        strb,
  output logic               extEdge,
  output logic               cfgDelayZero,
  output logic               delayDone,
  output logic               lengthDone
);

  logic [NUM_IN-1:0]  syncA, syncB, syncC;
  logic [NUM_IN-1:0]  riseVec, fallVec;
  logic [DELAY_W-1:0] delayCnt;
  logic [LEN_W-1:0]   lenCnt;

  // Two synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= digIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_edge
    assign riseVec[i] = syncB[i] & ~syncC[i];
    assign fallVec[i] = ~syncB[i] & syncC[i];

    AST_RISE_SYNCED: assert property (@(posedge clk) disable iff (!rstN)
      riseVec[i] |-> ($past(digIn[i], 2) && !$past(digIn[i], 3))); // R5
  end

  assign extEdge = extFalling ? fallVec[extSel] : riseVec[extSel];

  assign cfgDelayZero = (delayCycles == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strb.loadDelay) begin
      delayCnt <= delayCycles - DELAY_W'(1);
    end else if (strb.stepDelay) begin
      delayCnt <= delayCnt - DELAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCnt <= '0;
    end else if (strb.loadLength) begin
      lenCnt <= recordLen;
    end else if (strb.stepLength) begin
      lenCnt <= lenCnt - LEN_W'(1);
    end
  end

  assign delayDone  = (delayCnt == '0);
  assign lengthDone = (lenCnt == '0);

endmodule

// File: rtl/capture_trig_ctrl.sv
module capture_trig_ctrl
  import capture_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        acqEnable,
  input  logic        autoMode,
  input  logic        extMode,
  input  logic        forceTrig,
  input  logic        sampleStrobe,
  input  logic        extEdge,
  input  logic        cfgDelayZero,
  input  logic        delayDone,
  input  logic        lengthDone,
  output trigStrobe_t strb,
  output logic        captureEn,
  output logic        waiting
);

  trigState_t state, nextState, armState;
  logic       trigHit;

  // Automatic mode dominates; force works in any mode
  assign trigHit  = autoMode | (extMode & extEdge) | forceTrig;
  assign armState = cfgDelayZero ? ST_CAPTURE : ST_DELAY;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_WAIT: begin
        if (trigHit) begin
          nextState       = armState;
          strb.loadLength = cfgDelayZero;
          strb.loadDelay  = !cfgDelayZero;
        end
      end
      ST_DELAY: begin
        if (delayDone) begin
          nextState       = ST_CAPTURE;
          strb.loadLength = 1'b1;
        end else begin
          strb.stepDelay = 1'b1;
        end
      end
      ST_CAPTURE: begin
        if (sampleStrobe) begin
          if (!lengthDone) begin
            strb.stepLength = 1'b1;
          end else if (autoMode) begin
            nextState       = armState;
            strb.loadLength = cfgDelayZero;
            strb.loadDelay  = !cfgDelayZero;
          end else begin
            nextState = ST_WAIT;
          end
        end
      end
      default: nextState = ST_WAIT;
    endcase
    if (!acqEnable) begin
      nextState = ST_WAIT;
      strb      = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nextState;
  end

  assign captureEn = (state == ST_CAPTURE);
  assign waiting   = acqEnable && (state == ST_WAIT);

  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !acqEnable |=> !captureEn); // R8

  AST_LAST_SAMPLE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && sampleStrobe && lengthDone && !autoMode) |=> !captureEn); // R1

  AST_SEAMLESS_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && sampleStrobe && lengthDone && autoMode && cfgDelayZero && acqEnable)
      |=> captureEn); // R3

  AST_AUTO_NO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && acqEnable && waiting) |=> !waiting); // R6

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELAY && !delayDone && acqEnable) |=> (state == ST_DELAY)); // R7

  AST_ZERO_DELAY_START: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && forceTrig && cfgDelayZero) |=> captureEn); // R2

endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl
  import capture_trig_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int DELAY_W = 16,
  parameter int LEN_W   = 16,
  localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               acqEnable,
  input  logic               autoMode,
  input  logic               extMode,
  input  logic [SEL_W-1:0]   extSel,
  input  logic               extFalling,
  input  logic               forceTrig,
  input  logic [DELAY_W-1:0] delayCycles,
  input  logic [LEN_W-1:0]   recordLen,
  input  logic [NUM_IN-1:0]  digIn,
  input  logic               sampleStrobe,
  output logic               captureEn,
  output logic               waiting
);

  trigStrobe_t strb;
  logic        extEdge, cfgDelayZero, delayDone, lengthDone;

  capture_trig_datapath #(
    .NUM_IN (NUM_IN),
    .SEL_W  (SEL_W),
    .DELAY_W(DELAY_W),
    .LEN_W  (LEN_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .digIn       (digIn),
    .extSel      (extSel),
    .extFalling  (extFalling),
    .delayCycles (delayCycles),
    .recordLen   (recordLen),
    .strb        (strb),
    .extEdge     (extEdge),
    .cfgDelayZero(cfgDelayZero),
    .delayDone   (delayDone),
    .lengthDone  (lengthDone)
  );

  capture_trig_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .acqEnable   (acqEnable),
    .autoMode    (autoMode),
    .extMode     (extMode),
    .forceTrig   (forceTrig),
    .sampleStrobe(sampleStrobe),
    .extEdge     (extEdge),
    .cfgDelayZero(cfgDelayZero),
    .delayDone   (delayDone),
    .lengthDone  (lengthDone),
    .strb        (strb),
    .captureEn   (captureEn),
    .waiting     (waiting)
  );

endmodule

// File: tb/acq_trigger_ctrl_bench.sv
`timescale 1ns/1ps
module acq_trigger_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acqEnable = 1'b0, autoMode = 1'b0, extMode = 1'b0;
  logic [1:0]  extSel = 2'd0;
  logic        extFalling = 1'b0, forceTrig = 1'b0, sampleStrobe = 1'b0;
  logic [15:0] delayCycles = 16'd0, recordLen = 16'd0;
  logic [3:0]  digIn = 4'd0;
  logic        captureEn, waiting;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  acq_trigger_ctrl u_acq_trigger_ctrl (
    .clk(clk), .rstN(rstN), .acqEnable(acqEnable), .autoMode(autoMode),
    .extMode(extMode), .extSel(extSel), .extFalling(extFalling),
    .forceTrig(forceTrig), .delayCycles(delayCycles), .recordLen(recordLen),
    .digIn(digIn), .sampleStrobe(sampleStrobe), .captureEn(captureEn),
    .waiting(waiting)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Park in idle, then apply a new configuration and re-enable
  task automatic configure(input logic a, input logic e, input logic [1:0] s,
                           input logic f, input int d, input int l);
    acqEnable = 1'b0;
    step();
    autoMode = a; extMode = e; extSel = s; extFalling = f;
    delayCycles = 16'(d); recordLen = 16'(l);
    acqEnable = 1'b1;
  endtask

  task automatic strobe_once(input string req, input logic expAfter);
    sampleStrobe = 1'b1;
    step();
    sampleStrobe = 1'b0;
    chk(req, captureEn, expAfter);
    step();
    chk(req, captureEn, expAfter);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk("R10 captureEn after reset", captureEn, 1'b0);
    chk("R10 idle not waiting while disabled", waiting, 1'b0);
    acqEnable = 1'b1;
    step();
    chk("R9 waiting once enabled", waiting, 1'b1);
    repeat (4) begin
      step();
      chk("R6 no start with modes off", captureEn, 1'b0);
    end
  endtask

  task automatic t_force_record();
    configure(1'b0, 1'b0, 2'd0, 1'b0, 0, 2);
    step();
    forceTrig = 1'b1;
    step();
    forceTrig = 1'b0;
    chk("R2 zero delay start", captureEn, 1'b1);
    chk("R9 not waiting while capturing", waiting, 1'b0);
    for (int k = 0; k < 3; k++) strobe_once("R1 record of L+1 samples", k < 2);
    chk("R9 waiting after record", waiting, 1'b1);
  endtask

  task automatic t_delay();
    configure(1'b0, 1'b0, 2'd0, 1'b0, 5, 0);
    step();
    forceTrig = 1'b1;
    step();
    forceTrig = 1'b0;
    chk("R2 low after accept", captureEn, 1'b0);
    chk("R9 not waiting in delay", waiting, 1'b0);
    for (int i = 2; i <= 5; i++) begin
      if (i == 3) forceTrig = 1'b1;
      step();
      forceTrig = 1'b0;
      chk("R2 still in delay", captureEn, 1'b0);
    end
    step();
    chk("R2 capture after D cycles", captureEn, 1'b1);
    strobe_once("R1 single-sample record", 1'b0);
    repeat (8) begin
      step();
      chk("R7 force in delay not remembered", captureEn, 1'b0);
    end
  endtask

  task automatic t_external();
    configure(1'b0, 1'b1, 2'd2, 1'b0, 0, 0);
    digIn[1] = 1'b1;
    repeat (5) begin
      step();
      chk("R4 unselected input ignored", captureEn, 1'b0);
    end
    digIn[2] = 1'b1;
    step();
    step();
    chk("R5 not yet after two edges", captureEn, 1'b0);
    step();
    chk("R5 rising edge accepted at third edge", captureEn, 1'b1);
    strobe_once("R1 ext record end", 1'b0);
    extFalling = 1'b1;
    step();
    digIn[2] = 1'b0;
    step();
    step();
    chk("R5 falling not yet", captureEn, 1'b0);
    step();
    chk("R4 falling edge triggers", captureEn, 1'b1);
    strobe_once("R1 falling record end", 1'b0);
    digIn[2] = 1'b1;
    digIn[1] = 1'b0;
    repeat (6) begin
      step();
      chk("R4 rising ignored in falling mode", captureEn, 1'b0);
    end
    chk("R9 still waiting", waiting, 1'b1);
  endtask

  task automatic t_ignore_busy();
    configure(1'b0, 1'b1, 2'd0, 1'b0, 0, 3);
    digIn = 4'd0;
    repeat (3) step();
    digIn[0] = 1'b1;
    repeat (3) step();
    chk("R5 record started", captureEn, 1'b1);
    digIn[0] = 1'b0;
    step();
    step();
    digIn[0] = 1'b1;
    forceTrig = 1'b1;
    step();
    forceTrig = 1'b0;
    repeat (3) step();
    for (int k = 0; k < 4; k++) strobe_once("R7 busy triggers do not extend record", k < 3);
    repeat (6) begin
      step();
      chk("R7 busy trigger not queued", captureEn, 1'b0);
    end
    chk("R9 waiting after ignored triggers", waiting, 1'b1);
  endtask

  task automatic t_disable();
    configure(1'b0, 1'b0, 2'd0, 1'b0, 0, 5);
    step();
    forceTrig = 1'b1;
    step();
    forceTrig = 1'b0;
    chk("R2 forced start", captureEn, 1'b1);
    acqEnable = 1'b0;
    step();
    chk("R8 capture stops next edge", captureEn, 1'b0);
    chk("R9 not waiting while disabled", waiting, 1'b0);
    forceTrig = 1'b1;
    step();
    forceTrig = 1'b0;
    step();
    chk("R8 force ignored while disabled", captureEn, 1'b0);
    acqEnable = 1'b1;
    step();
    chk("R8 idle after re-enable", captureEn, 1'b0);
    chk("R8 waiting after re-enable", waiting, 1'b1);
  endtask

  task automatic t_auto_seamless();
    configure(1'b1, 1'b0, 2'd0, 1'b0, 0, 1);
    step();
    chk("R6 auto starts without input", captureEn, 1'b1);
    for (int k = 0; k < 4; k++) strobe_once("R3 seamless auto stream", 1'b1);
    chk("R9 never waiting in auto", waiting, 1'b0);
  endtask

  task automatic t_auto_dead();
    configure(1'b1, 1'b0, 2'd0, 1'b0, 3, 0);
    for (int i = 1; i <= 3; i++) begin
      step();
      chk("R2 first auto record delayed", captureEn, 1'b0);
    end
    step();
    chk("R2 first auto record starts", captureEn, 1'b1);
    sampleStrobe = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      step();
      sampleStrobe = 1'b0;
      chk("R3 dead time low", captureEn, 1'b0);
    end
    step();
    chk("R3 re-trigger after dead time", captureEn, 1'b1);
  endtask

  task automatic t_precedence();
    configure(1'b1, 1'b1, 2'd3, 1'b0, 0, 0);
    step();
    chk("R6 auto overrides external", captureEn, 1'b1);
    configure(1'b0, 1'b1, 2'd3, 1'b0, 0, 0);
    repeat (4) begin
      step();
      chk("R6 external needs an edge", captureEn, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_force_record();
    t_delay();
    t_external();
    t_ignore_busy();
    t_disable();
    t_auto_seamless();
    t_auto_dead();
    t_precedence();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule